// File: doc/BRIEF.md
# Interrupt Flag Controller

This block gathers ten interrupt events into two register groups and drives one level-sensitive interrupt request to the CPU. The first group is for on-chip functions. It holds a timer overflow, falling edges on two external pins, and a keyboard report tick that the block generates itself. The second group holds six USB endpoint and bus events. These events arrive from the USB engine as pulses one clock long.

Each group has three registers on a simple register bus:
- a read-only flag register,
- a write-only clear register,
- a read/write enable register.

Only hardware can set a flag, and only a write of 1 to the matching clear bit can remove it. A flag whose enable bit is 0 does not raise the request, but software can still read it. The two external pins pass through a synchroniser before edge detection. A free-running divider produces the periodic keyboard tick.

Top module: `irq_flag_ctrl`

## Requirements
- R1: The function group occupies address 0 (flags, read), 1 (clear, write) and 2 (enable, read/write), with bit positions timer=0, pin0 edge=1, pin1 edge=2, keyboard tick=3.
- R2: The USB group occupies address 3 (flags), 4 (clear) and 5 (enable), with bit positions IN0 done=0, OUT0 done=1, IN1 done=2, IN2 done=3, SETUP done=6, suspend=7.
- R3: A flag becomes 1 only through its hardware event. Writing to a flag register (address 0 or 3) changes nothing.
- R4: Writing a 1 to a bit of a clear register clears that flag in the next cycle. Writing a 0 leaves the flag as it was.
- R5: A 1-to-0 transition on an external pin sets its flag after a two-flop synchroniser. A 0-to-1 transition sets nothing, and a pin held low does not set the flag again.
- R6: The keyboard tick flag is set once every TICK_DIV clock cycles.
- R7: `irq` is high exactly when some flag and its enable bit are both 1. A flag that is not enabled stays readable and does not raise `irq`.
- R8: After reset, every flag and enable bit is 0 and `irq` is low.
- R9: If a hardware event and a clear write hit the same bit in the same cycle, the flag ends up set.
- R10: Unused bits read as 0 and ignore writes. These are bits 7..4 of the function group and bits 5..4 of the USB group. Clear registers and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| ext_pin0 | input | 1 | External pin 0, asynchronous, idle high |
| ext_pin1 | input | 1 | External pin 1, asynchronous, idle high |
| tmr_ovf | input | 1 | Timer overflow pulse |
| usb_in0_done | input | 1 | Endpoint 0 IN done pulse |
| usb_out0_done | input | 1 | Endpoint 0 OUT done pulse |
| usb_in1_done | input | 1 | Endpoint 1 IN done pulse |
| usb_in2_done | input | 1 | Endpoint 2 IN done pulse |
| usb_setup_done | input | 1 | Endpoint 0 SETUP done pulse |
| usb_suspend | input | 1 | Suspend detected pulse |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
The hardest state to reach from the ports is a hardware event and a software clear landing on the same bit in the same cycle. The bench lines them up on one clock edge: it asserts the timer pulse during the very negative half-cycle in which it drives the clear write. It then reads the flag back.

The keyboard tick is a second hard case because it runs freely from reset. The bench first polls until the tick appears. It then clears the flag and samples a few cycles before and after the predicted next tick, which pins the period without knowing the counter's phase.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    localparam int REG_W = 8;

    // register addresses
    localparam int ADR_FN_FLAG  = 0;
    localparam int ADR_FN_CLR   = 1;
    localparam int ADR_FN_EN    = 2;
    localparam int ADR_USB_FLAG = 3;
    localparam int ADR_USB_CLR  = 4;
    localparam int ADR_USB_EN   = 5;

    // function group bit positions
    localparam int FN_TMR  = 0;
    localparam int FN_PIN0 = 1;
    localparam int FN_PIN1 = 2;
    localparam int FN_KBD  = 3;

    // USB group bit positions
    localparam int USB_IN0   = 0;
    localparam int USB_OUT0  = 1;
    localparam int USB_IN1   = 2;
    localparam int USB_IN2   = 3;
    localparam int USB_SETUP = 6;
    localparam int USB_SUSP  = 7;

    localparam logic [REG_W-1:0] FN_VALID  = 8'h0F;
    localparam logic [REG_W-1:0] USB_VALID = 8'hCF;

    typedef struct packed {
        logic [REG_W-1:0] flags;
        logic [REG_W-1:0] en;
    } grp_state_t;
endpackage

// File: rtl/irq_pin_fall.sv
module irq_pin_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } fall_state_t;

    fall_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pin};
        st_d.prev = st_q.sync[STAGES-1];
    end

    // pins idle high: reset to 1 so no edge is seen leaving reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign fall = st_q.prev & ~st_q.sync[STAGES-1];
endmodule

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
    parameter int DIV = 24000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == LAST) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/irq_flag_group.sv
module irq_flag_group
    import irq_flag_pkg::*;
#(
    parameter logic [REG_W-1:0] VALID = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] hw_set,
    input  logic             clr_we,
    input  logic             en_we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] flags,
    output logic [REG_W-1:0] enable,
    output logic             pend
);
    grp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we) st_d.flags = st_d.flags & ~wdata;
        // hardware set applied after the clear: set wins on collision
        st_d.flags = (st_d.flags | hw_set) & VALID;
        if (en_we) st_d.en = wdata & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags  = st_q.flags;
    assign enable = st_q.en;
    assign pend   = |(st_q.flags & st_q.en);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_flag_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int TICK_DIV    = 24000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ext_pin0,
    input  logic              ext_pin1,
    input  logic              tmr_ovf,
    input  logic              usb_in0_done,
    input  logic              usb_out0_done,
    input  logic              usb_in1_done,
    input  logic              usb_in2_done,
    input  logic              usb_setup_done,
    input  logic              usb_suspend,
    output logic              irq
);
    localparam int NPIN = 2;

    logic [NPIN-1:0]  pins, falls;
    logic             kbd_tick;
    logic [REG_W-1:0] fn_set, usb_set;
    logic [REG_W-1:0] fn_flags, fn_en, usb_flags, usb_en;
    logic             fn_pend, usb_pend;
    logic             fn_clr_we, fn_en_we, usb_clr_we, usb_en_we;

    assign pins = {ext_pin1, ext_pin0};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        irq_pin_fall #(.STAGES(SYNC_STAGES)) u_fall (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[g]),
            .fall (falls[g])
        );
    end

    irq_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (kbd_tick)
    );

    always_comb begin
        fn_set            = '0;
        fn_set[FN_TMR]    = tmr_ovf;
        fn_set[FN_PIN0]   = falls[0];
        fn_set[FN_PIN1]   = falls[1];
        fn_set[FN_KBD]    = kbd_tick;
        usb_set            = '0;
        usb_set[USB_IN0]   = usb_in0_done;
        usb_set[USB_OUT0]  = usb_out0_done;
        usb_set[USB_IN1]   = usb_in1_done;
        usb_set[USB_IN2]   = usb_in2_done;
        usb_set[USB_SETUP] = usb_setup_done;
        usb_set[USB_SUSP]  = usb_suspend;
    end

    assign fn_clr_we  = reg_wr && (reg_addr == ADDR_W'(ADR_FN_CLR));
    assign fn_en_we   = reg_wr && (reg_addr == ADDR_W'(ADR_FN_EN));
    assign usb_clr_we = reg_wr && (reg_addr == ADDR_W'(ADR_USB_CLR));
    assign usb_en_we  = reg_wr && (reg_addr == ADDR_W'(ADR_USB_EN));

    irq_flag_group #(.VALID(FN_VALID)) u_fn (
        .clk   (clk),
        .rst_n (rst_n),
        .hw_set(fn_set),
        .clr_we(fn_clr_we),
        .en_we (fn_en_we),
        .wdata (reg_wdata),
        .flags (fn_flags),
        .enable(fn_en),
        .pend  (fn_pend)
    );

    irq_flag_group #(.VALID(USB_VALID)) u_usb (
        .clk   (clk),
        .rst_n (rst_n),
        .hw_set(usb_set),
        .clr_we(usb_clr_we),
        .en_we (usb_en_we),
        .wdata (reg_wdata),
        .flags (usb_flags),
        .enable(usb_en),
        .pend  (usb_pend)
    );

    always_comb begin
        reg_rdata = '0;
        if      (reg_addr == ADDR_W'(ADR_FN_FLAG))  reg_rdata = fn_flags;
        else if (reg_addr == ADDR_W'(ADR_FN_EN))    reg_rdata = fn_en;
        else if (reg_addr == ADDR_W'(ADR_USB_FLAG)) reg_rdata = usb_flags;
        else if (reg_addr == ADDR_W'(ADR_USB_EN))   reg_rdata = usb_en;
    end

    assign irq = fn_pend | usb_pend;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic              tmr_ovf,
    input logic              usb_in0_done,
    input logic [7:0]        fn_flags,
    input logic [7:0]        fn_en,
    input logic [7:0]        usb_flags,
    input logic [7:0]        usb_en,
    input logic              irq
);
    // R3: a flag rises only after its hardware event
    p_hw_only_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fn_flags[0]) |-> $past(tmr_ovf));
    p_usb_hw_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(usb_flags[0]) |-> $past(usb_in0_done));

    // R4: a write of 1 to the clear bit removes the flag
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(1) && reg_wdata[0] && !tmr_ovf) |=> !fn_flags[0]);

    // R9: a hardware event always leaves its flag set
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> fn_flags[0]);

    // R7: an enabled flag raises irq, and irq stays low without one
    p_irq_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_flags[0] && fn_en[0]) |-> irq);
    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (((fn_flags & fn_en) == 8'h00) && ((usb_flags & usb_en) == 8'h00)) |-> !irq);

    // R10: unused bits stay zero
    p_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_flags[7:4] == 4'h0) && (fn_en[7:4] == 4'h0) &&
        (usb_flags[5:4] == 2'b00) && (usb_en[5:4] == 2'b00));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .tmr_ovf     (tmr_ovf),
    .usb_in0_done(usb_in0_done),
    .fn_flags    (fn_flags),
    .fn_en       (fn_en),
    .usb_flags   (usb_flags),
    .usb_en      (usb_en),
    .irq         (irq)
);

// File: tb/irq_flag_ctrl_test.sv
module irq_flag_ctrl_test;
    localparam int TD = 3000;
    localparam int AW = 4;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          ext_pin0 = 1, ext_pin1 = 1;
    logic          tmr_ovf = 0;
    logic [5:0]    ev = '0; // {susp, setup, in2, in1, out0, in0}
    logic          irq;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    irq_flag_ctrl #(.ADDR_W(AW), .TICK_DIV(TD), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_pin0(ext_pin0), .ext_pin1(ext_pin1), .tmr_ovf(tmr_ovf),
        .usb_in0_done(ev[0]), .usb_out0_done(ev[1]), .usb_in1_done(ev[2]),
        .usb_in2_done(ev[3]), .usb_setup_done(ev[4]), .usb_suspend(ev[5]),
        .irq(irq)
    );

    typedef struct packed {
        logic       tmr;
        logic [5:0] evs;
        logic [7:0] en_fn;
        logic [7:0] en_usb;
        logic [7:0] exp_fn;
        logic [7:0] exp_usb;
        logic       exp_irq;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{1'b1, 6'b000000, 8'h01, 8'h00, 8'h01, 8'h00, 1'b1},
        '{1'b1, 6'b000000, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0},
        '{1'b0, 6'b000001, 8'h00, 8'h01, 8'h00, 8'h01, 1'b1},
        '{1'b0, 6'b000010, 8'h00, 8'h01, 8'h00, 8'h02, 1'b0},
        '{1'b0, 6'b100000, 8'h00, 8'h80, 8'h00, 8'h80, 1'b1},
        '{1'b0, 6'b010000, 8'h00, 8'h80, 8'h00, 8'h40, 1'b0},
        '{1'b0, 6'b001100, 8'h0F, 8'h08, 8'h00, 8'h0C, 1'b1},
        '{1'b1, 6'b111111, 8'h0E, 8'h30, 8'h01, 8'hCF, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = AW'(a); reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = AW'(a);
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic t, input logic [5:0] e);
        @(negedge clk);
        tmr_ovf = t; ev = e;
        @(negedge clk);
        tmr_ovf = 0; ev = '0;
    endtask

    task automatic irq_chk(input string req, input logic exp);
        #1 chk(req, {7'b0, irq}, {7'b0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        bit seen;

        repeat (3) @(negedge clk);
        // R8: reset values
        irq_chk("R8 irq in reset", 1'b0);
        rst_n = 1;
        rd(0, d); chk("R8 fn flags", d, 8'h00);
        rd(2, d); chk("R8 fn enable", d, 8'h00);
        rd(3, d); chk("R8 usb flags", d, 8'h00);
        rd(5, d); chk("R8 usb enable", d, 8'h00);

        // table: R1 R2 R7 R10
        for (int i = 0; i < 8; i++) begin
            wr(1, 8'hFF); wr(4, 8'hFF);
            wr(2, TBL[i].en_fn); wr(5, TBL[i].en_usb);
            pulse(TBL[i].tmr, TBL[i].evs);
            rd(0, d); chk("R1 fn flags", d, TBL[i].exp_fn);
            rd(3, d); chk("R2 usb flags", d, TBL[i].exp_usb);
            irq_chk("R7 irq level", TBL[i].exp_irq);
            rd(2, d); chk("R10 fn enable readback", d, TBL[i].en_fn & 8'h0F);
            rd(5, d); chk("R10 usb enable readback", d, TBL[i].en_usb & 8'hCF);
        end

        // R4: partial clear
        wr(1, 8'hFF); wr(4, 8'hFF); wr(2, 8'h00); wr(5, 8'h00);
        pulse(1'b0, 6'b111111);
        wr(4, 8'h41);
        rd(3, d); chk("R4 partial clear", d, 8'h8E);
        wr(4, 8'h00);
        rd(3, d); chk("R4 zero write keeps flags", d, 8'h8E);

        // R3: writes to flag registers do nothing
        wr(4, 8'hFF);
        pulse(1'b1, 6'b000000);
        wr(0, 8'h00); wr(3, 8'hFF);
        rd(0, d); chk("R3 fn flag write ignored", d, 8'h01);
        rd(3, d); chk("R3 usb flag write ignored", d, 8'h00);

        // R9: set and clear in the same cycle
        wr(1, 8'hFF);
        @(negedge clk);
        tmr_ovf = 1; reg_addr = AW'(1); reg_wdata = 8'h01; reg_wr = 1;
        @(negedge clk);
        tmr_ovf = 0; reg_wr = 0;
        rd(0, d); chk("R9 set wins", d, 8'h01);
        wr(1, 8'h01);
        rd(0, d); chk("R4 clear after collision", d, 8'h00);

        // R10: unmapped and write-only addresses read zero
        rd(1, d); chk("R10 clear reg reads 0", d, 8'h00);
        rd(4, d); chk("R10 usb clear reg reads 0", d, 8'h00);
        rd(6, d); chk("R10 unmapped 6", d, 8'h00);
        rd(7, d); chk("R10 unmapped 7", d, 8'h00);

        // R5: pin edges
        wr(2, 8'h02);
        @(negedge clk); ext_pin0 = 0;
        repeat (5) @(negedge clk);
        rd(0, d); chk("R5 pin0 fall", d, 8'h02);
        irq_chk("R7 pin0 irq", 1'b1);
        wr(1, 8'h02);
        repeat (5) @(negedge clk);
        rd(0, d); chk("R5 held low no reset", d, 8'h00);
        ext_pin0 = 1;
        repeat (5) @(negedge clk);
        rd(0, d); chk("R5 rising ignored", d, 8'h00);
        ext_pin1 = 0;
        repeat (5) @(negedge clk);
        rd(0, d); chk("R5 pin1 fall", d, 8'h04);
        irq_chk("R7 masked pin1", 1'b0);
        ext_pin1 = 1;
        wr(1, 8'hFF); wr(2, 8'h00);

        // R6: keyboard tick period
        seen = 0;
        for (int k = 0; k < 2 * TD && !seen; k++) begin
            rd(0, d);
            if (d[3]) seen = 1;
        end
        chk("R6 tick seen", {7'b0, seen}, 8'h01);
        wr(1, 8'h08);
        repeat (TD - 5) @(negedge clk);
        rd(0, d); chk("R6 no early tick", d & 8'h08, 8'h00);
        repeat (4) @(negedge clk);
        rd(0, d); chk("R6 tick on period", d & 8'h08, 8'h08);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule